// File: doc/BRIEF.md
# Dual-Enable Two-Clock FIFO with Reset-Strapped Mode

This block is a first-in first-out buffer whose write and read sides run on separate clocks. Each side has two active-low enables, and a transfer takes place only when both enables of that side are asserted. The depth is a parameter and supports 64, 256, 512, 1024, 2048, 4096 or 8192 words of 9 bits. Four active-low status outputs are provided: empty, full, and two programmable thresholds (almost-empty and almost-full). The data output has an active-low output enable and is high impedance when that enable is off.

One input, `wrEn2LdN`, has two roles. Its level while reset is held selects the role. If it is low during reset, the block enters load mode. In that mode the input becomes a load control that writes and reads back the two threshold offsets. If it is high during reset, the block enters expansion mode. In that mode the input is a second write enable, so external logic can steer writes between several devices, and both offsets keep their default value.

Top module: `dual_enable_fifo`

## Requirements
- R1: A word is written to the FIFO only on a `wrClk` edge where both write enables are asserted. In expansion mode this means `wrEn1N`=0 and `wrEn2LdN`=0. In load mode this means `wrEn1N`=0 and `wrEn2LdN`=1. With any other combination, nothing is stored.
- R2: A word is read only on an `rdClk` edge where `rdEn1N`=0 and `rdEn2N`=0. Holding `rdEn2N` at 0 permanently gives ordinary single-enable reads controlled by `rdEn1N`.
- R3: Words leave in the order they were written. The word read at an `rdClk` edge appears on `dataOut` right after that edge and is held until the next read.
- R4: `emptyN` is 0 when the FIFO holds no words. A read attempted while the FIFO is empty changes neither the stored contents nor `dataOut`.
- R5: `fullN` is 0 when DEPTH words are stored. A write attempted while the FIFO is full is discarded.
- R6: `almostEmptyN` is 0 when the stored word count is less than or equal to the almost-empty offset.
- R7: `almostFullN` is 0 when the number of free locations is less than or equal to the almost-full offset.
- R8: The mode is fixed by the level of `wrEn2LdN` while `rstN` is 0. A low level selects load mode and a high level selects expansion mode. The mode does not change until the next reset.
- R9: In load mode, each `wrClk` edge with `wrEn1N`=0 and `wrEn2LdN`=0 stores `dataIn` into an offset register. The destination alternates: almost-empty first, then almost-full, then almost-empty again. Each `rdClk` edge with `wrEn2LdN`=0 and both read enables at 0 places an offset on `dataOut`, using the same alternating order. Neither access touches the FIFO contents.
- R10: After reset, both offsets are 7. In expansion mode they remain 7 and cannot be changed.
- R11: While `outEnN` is 1, `dataOut` is high impedance on all 9 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Active-low reset for both sides; `wrEn2LdN` is sampled while it is low |
| dataIn | input | 9 | Write data, also the offset value in load mode |
| wrEn1N | input | 1 | First write enable, active low |
| wrEn2LdN | input | 1 | Second write enable or load control, depending on the mode |
| rdEn1N | input | 1 | First read enable, active low |
| rdEn2N | input | 1 | Second read enable, active low |
| outEnN | input | 1 | Output enable for `dataOut`, active low |
| dataOut | output | 9 | Read data or offset read-back; high impedance when disabled |
| emptyN | output | 1 | Empty flag, active low |
| almostEmptyN | output | 1 | Almost-empty flag, active low |
| almostFullN | output | 1 | Almost-full flag, active low |
| fullN | output | 1 | Full flag, active low |

## Verification
The hardest condition to reach is a write attempted while the FIFO is exactly full, because the full decision relies on the read pointer after it has been synchronised. The stimulus produces it by writing several more words than the depth while no reads are issued. It then drains the FIFO and confirms that none of the extra words were stored. Programmed thresholds can only be observed after a reset with the load strap low. The stimulus therefore resets again in load mode, loads two distinct offsets, reads them back in their alternating order, and then fills the FIFO to levels just on each side of both new thresholds.

// File: rtl/dual_fifo_pkg.sv
package dual_fifo_pkg;
  // Strobes from control to datapath; the write pair is in wrClk, the read pair in rdClk
  typedef struct packed {
    logic wrPush;   // store dataIn into the array
    logic offLoad;  // store dataIn into the selected offset register
    logic rdPop;    // move array word to output register
    logic offRead;  // move selected offset to output register
  } fifoStrobe_t;
endpackage

// File: rtl/dual_fifo_sync.sv
module dual_fifo_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/dual_fifo_ctrl.sv
module dual_fifo_ctrl
  import dual_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 64,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PTR_W  = ADDR_W + 1
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic              wrEn1N,
  input  logic              wrEn2LdN,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic [DATA_W-1:0] aeOff,
  input  logic [DATA_W-1:0] afOff,
  output fifoStrobe_t       strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              wrOffSel,
  output logic              rdOffSel,
  output logic              loadModeW,
  output logic              emptyN,
  output logic              almostEmptyN,
  output logic              almostFullN,
  output logic              fullN
);
  localparam int CMP_W = (PTR_W > DATA_W) ? PTR_W : DATA_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic loadModeR;
  logic [PTR_W-1:0] wrBin, wrGray, rdBin, rdGray;
  logic [PTR_W-1:0] rdGraySync, wrGraySync, rdBinSync, wrBinSync;
  logic [PTR_W-1:0] fillW, fillR, freeW;
  logic fullW, emptyR, wrBoth, rdBoth;

  // Mode strap: sampled in each domain while reset is held
  always_ff @(posedge wrClk) begin
    if (!rstN) loadModeW <= !wrEn2LdN;
  end

  always_ff @(posedge rdClk) begin
    if (!rstN) loadModeR <= !wrEn2LdN;
  end

  // Pointer crossing
  dual_fifo_sync #(.W(PTR_W)) uRdToWr (
    .clk(wrClk), .rstN(rstN), .din(rdGray), .dout(rdGraySync));
  dual_fifo_sync #(.W(PTR_W)) uWrToRd (
    .clk(rdClk), .rstN(rstN), .din(wrGray), .dout(wrGraySync));

  always_comb begin
    for (int i = 0; i < PTR_W; i++) begin
      rdBinSync[i] = ^(rdGraySync >> i);
      wrBinSync[i] = ^(wrGraySync >> i);
    end
  end

  // ---------------- write domain ----------------
  assign fillW  = wrBin - rdBinSync;
  assign freeW  = DEPTH_P - fillW;
  assign fullW  = (fillW == DEPTH_P);
  assign wrBoth = !wrEn1N && (loadModeW ? wrEn2LdN : !wrEn2LdN);

  assign strobe.wrPush  = wrBoth && !fullW;
  assign strobe.offLoad = loadModeW && !wrEn1N && !wrEn2LdN;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin    <= '0;
      wrGray   <= '0;
      wrOffSel <= 1'b0;
    end else begin
      if (strobe.wrPush) begin
        wrBin  <= wrBin + PTR_W'(1);
        wrGray <= (wrBin + PTR_W'(1)) ^ ((wrBin + PTR_W'(1)) >> 1);
      end
      if (strobe.offLoad) wrOffSel <= !wrOffSel;
    end
  end

  assign wrAddr      = wrBin[ADDR_W-1:0];
  assign fullN       = !fullW;
  assign almostFullN = !(CMP_W'(freeW) <= CMP_W'(afOff));

  // ---------------- read domain ----------------
  assign fillR  = wrBinSync - rdBin;
  assign emptyR = (fillR == '0);
  assign rdBoth = !rdEn1N && !rdEn2N;

  assign strobe.offRead = loadModeR && !wrEn2LdN && rdBoth;
  assign strobe.rdPop   = rdBoth && !emptyR && !strobe.offRead;

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin    <= '0;
      rdGray   <= '0;
      rdOffSel <= 1'b0;
    end else begin
      if (strobe.rdPop) begin
        rdBin  <= rdBin + PTR_W'(1);
        rdGray <= (rdBin + PTR_W'(1)) ^ ((rdBin + PTR_W'(1)) >> 1);
      end
      if (strobe.offRead) rdOffSel <= !rdOffSel;
    end
  end

  assign rdAddr       = rdBin[ADDR_W-1:0];
  assign emptyN       = !emptyR;
  assign almostEmptyN = !(CMP_W'(fillR) <= CMP_W'(aeOff));

  // ---------------- assertions ----------------
  AST_NO_OVERFLOW: assert property (@(posedge wrClk) disable iff (!rstN)
    fillW <= DEPTH_P); // R5
  AST_FULL_HOLDS_WRPTR: assert property (@(posedge wrClk) disable iff (!rstN)
    fullW |=> $stable(wrBin)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge rdClk) disable iff (!rstN)
    fillR <= DEPTH_P); // R4
  AST_EMPTY_HOLDS_RDPTR: assert property (@(posedge rdClk) disable iff (!rstN)
    emptyR |=> $stable(rdBin)); // R4
  AST_MODE_FROZEN: assert property (@(posedge wrClk) disable iff (!rstN)
    $stable(loadModeW)); // R8
  AST_ONE_ROLE: assert property (@(posedge wrClk) disable iff (!rstN)
    $onehot0({strobe.wrPush, strobe.offLoad})); // R1
endmodule

// File: rtl/dual_fifo_datapath.sv
module dual_fifo_datapath
  import dual_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 64,
  parameter logic [DATA_W-1:0] DEF_OFFSET = DATA_W'(7),
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              wrOffSel,
  input  logic              rdOffSel,
  input  logic              loadMode,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] aeOff,
  output logic [DATA_W-1:0] afOff,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strobe.wrPush) mem[wrAddr] <= dataIn;
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOff <= DEF_OFFSET;
      afOff <= DEF_OFFSET;
    end else if (strobe.offLoad) begin
      if (wrOffSel) afOff <= dataIn;
      else          aeOff <= dataIn;
    end
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strobe.rdPop)   rdData <= mem[rdAddr];
    else if (strobe.offRead) rdData <= rdOffSel ? afOff : aeOff;
  end

  AST_DEFAULT_OFFSETS: assert property (@(posedge wrClk) disable iff (!rstN)
    !loadMode |-> (aeOff == DEF_OFFSET && afOff == DEF_OFFSET)); // R10
endmodule

// File: rtl/dual_enable_fifo.sv
module dual_enable_fifo
  import dual_fifo_pkg::*;
#(
  parameter int DATA_W = 9,
  parameter int DEPTH  = 64,
  parameter int DEF_OFFSET = 7,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              wrEn1N,
  input  logic              wrEn2LdN,
  input  logic              rdEn1N,
  input  logic              rdEn2N,
  input  logic              outEnN,
  output logic [DATA_W-1:0] dataOut,
  output logic              emptyN,
  output logic              almostEmptyN,
  output logic              almostFullN,
  output logic              fullN
);
  fifoStrobe_t       strobe;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              wrOffSel, rdOffSel, loadModeW;
  logic [DATA_W-1:0] aeOff, afOff, rdData;

  dual_fifo_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEn1N(wrEn1N), .wrEn2LdN(wrEn2LdN), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N),
    .aeOff(aeOff), .afOff(afOff), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrOffSel(wrOffSel), .rdOffSel(rdOffSel),
    .loadModeW(loadModeW), .emptyN(emptyN), .almostEmptyN(almostEmptyN),
    .almostFullN(almostFullN), .fullN(fullN));

  dual_fifo_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH),
                       .DEF_OFFSET(DATA_W'(DEF_OFFSET))) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strobe(strobe),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrOffSel(wrOffSel), .rdOffSel(rdOffSel),
    .loadMode(loadModeW), .dataIn(dataIn), .aeOff(aeOff), .afOff(afOff),
    .rdData(rdData));

  assign dataOut = outEnN ? {DATA_W{1'bz}} : rdData;
endmodule

// File: tb/tb_dual_enable_fifo.sv
module tb_dual_enable_fifo;
  localparam int  CLK_P = 10;
  localparam int  RD_P  = 14;
  localparam int  DEPTH = 64;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic [8:0] dataIn = '0;
  logic wrEn1N = 1, wrEn2LdN = 1, rdEn1N = 1, rdEn2N = 1, outEnN = 0;
  wire  [8:0] dataOut;
  wire  emptyN, almostEmptyN, almostFullN, fullN;

  int nChecks = 0, nFail = 0;
  bit done = 0;
  logic idleLd = 1;
  logic [8:0] model [$];

  always #(CLK_P/2) wrClk = ~wrClk;
  always #(RD_P/2)  rdClk = ~rdClk;

  dual_enable_fifo #(.DEPTH(DEPTH)) dut (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .dataIn(dataIn),
    .wrEn1N(wrEn1N), .wrEn2LdN(wrEn2LdN), .rdEn1N(rdEn1N), .rdEn2N(rdEn2N),
    .outEnN(outEnN), .dataOut(dataOut), .emptyN(emptyN),
    .almostEmptyN(almostEmptyN), .almostFullN(almostFullN), .fullN(fullN));

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expAe(int cnt, int thr); return (cnt > thr) ? 1 : 0; endfunction
  function automatic int expAf(int cnt, int thr); return ((DEPTH - cnt) > thr) ? 1 : 0; endfunction

  task automatic checkFlags(input string req, input int aeThr, input int afThr);
    int cnt = model.size();
    chk({req, " emptyN"},       emptyN,       (cnt != 0) ? 1 : 0);
    chk({req, " fullN"},        fullN,        (cnt != DEPTH) ? 1 : 0);
    chk({req, " almostEmptyN"}, almostEmptyN, expAe(cnt, aeThr));
    chk({req, " almostFullN"},  almostFullN,  expAf(cnt, afThr));
  endtask

  task automatic settle();
    repeat (5) @(negedge wrClk);
    repeat (5) @(negedge rdClk);
  endtask

  task automatic doReset(input logic strap);
    rstN = 0; wrEn2LdN = strap; wrEn1N = 1; rdEn1N = 1; rdEn2N = 1;
    repeat (4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
    rstN = 1;
    repeat (2) @(negedge wrClk);
    wrEn2LdN = 1; idleLd = 1;
    model.delete();
    settle();
  endtask

  task automatic doWrite(input logic e1, input logic e2, input logic [8:0] d);
    @(negedge wrClk);
    wrEn1N = e1; wrEn2LdN = e2; dataIn = d;
    @(negedge wrClk);
    wrEn1N = 1; wrEn2LdN = idleLd;
  endtask

  task automatic doRead(input logic r1, input logic r2, output logic [8:0] q);
    @(negedge rdClk);
    rdEn1N = r1; rdEn2N = r2;
    @(negedge rdClk);
    q = dataOut;
    rdEn1N = 1; rdEn2N = 1;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [8:0] q, prev;
    void'($urandom(32'h00C0FFEE));

    // Expansion mode (strap high)
    doReset(1'b1);
    checkFlags("R4 R6 R10 reset", 7, 7);

    // R1: single write enable asserted stores nothing
    doWrite(1'b0, 1'b1, 9'h055);
    doWrite(1'b1, 1'b0, 9'h0AA);
    settle();
    chk("R1 no write with one enable", emptyN, 0);

    // R4: read while empty ignored
    doRead(1'b0, 1'b0, q);
    chk("R4 read on empty keeps dataOut", q, 0);

    // Random bursts with mixed enable patterns
    for (int round = 0; round < 4; round++) begin
      int n = 5 + ($urandom % 30);
      for (int i = 0; i < n; i++) begin
        logic [1:0] p = 2'($urandom % 4);
        logic [8:0] d = 9'($urandom);
        doWrite(p[0], p[1], d);
        if (p == 2'b00) model.push_back(d);
      end
      settle();
      checkFlags("R1 R6 R7 R10 random fill", 7, 7);
      while (model.size() > 0) begin
        logic [1:0] p = 2'($urandom % 4);
        if (round == 3) p[1] = 1'b0;      // R2: second read enable tied low
        doRead(p[0], p[1], q);
        if (p == 2'b00) chk("R2 R3 read order", q, model.pop_front());
      end
      settle();
      checkFlags("R4 drained", 7, 7);
    end

    // R5: overfill, extras ignored
    for (int i = 0; i < DEPTH + 6; i++) begin
      doWrite(1'b0, 1'b0, 9'(i + 100));
      if (model.size() < DEPTH) model.push_back(9'(i + 100));
    end
    settle();
    checkFlags("R5 R7 full", 7, 7);
    for (int i = 0; i < DEPTH; i++) begin
      doRead(1'b0, 1'b0, q);
      chk("R5 R3 drain after overfill", q, model.pop_front());
    end
    prev = q;
    settle();
    doRead(1'b0, 1'b0, q);
    chk("R4 extra read ignored", q, prev);
    chk("R4 R5 empty after drain", emptyN, 0);
    doWrite(1'b0, 1'b0, 9'h1C3);
    settle();
    doRead(1'b0, 1'b0, q);
    chk("R5 pointers intact after overfill", q, 9'h1C3);

    // R11: output enable
    outEnN = 1; #1;
    chk("R11 high impedance", (dataOut === 9'bzzzzzzzzz) ? 1 : 0, 1);
    outEnN = 0; #1;
    chk("R11 driven again", dataOut, 9'h1C3);

    // Load mode (strap low)
    doReset(1'b0);
    checkFlags("R8 R10 load mode defaults", 7, 7);
    doWrite(1'b0, 1'b0, 9'd3);
    doWrite(1'b0, 1'b0, 9'd10);
    settle();
    chk("R9 load does not store data", emptyN, 0);
    wrEn2LdN = 0;
    doRead(1'b0, 1'b0, q); chk("R9 readback ae offset", q, 3);
    doRead(1'b0, 1'b0, q); chk("R9 readback af offset", q, 10);
    doRead(1'b0, 1'b0, q); chk("R9 readback wraps", q, 3);
    wrEn2LdN = 1;
    settle();
    chk("R6 programmed ae empty", almostEmptyN, 0);

    doWrite(1'b1, 1'b1, 9'h011);           // R1: no enables
    for (int i = 0; i < 55; i++) begin
      logic [8:0] d = 9'($urandom);
      doWrite(1'b0, 1'b1, d);
      model.push_back(d);
    end
    settle();
    checkFlags("R1 R7 R8 programmed af", 3, 10);
    for (int i = 0; i < 52; i++) begin
      doRead(1'b0, 1'b0, q);
      chk("R3 load mode order", q, model.pop_front());
    end
    settle();
    checkFlags("R6 programmed ae", 3, 10);
    while (model.size() > 0) begin
      doRead(1'b0, 1'b0, q);
      chk("R3 load mode tail", q, model.pop_front());
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule